// File: doc/BRIEF.md
# TDM Frame Synchronizer with Multiframe Counter

This block keeps the timing of a serial time-division multiplexed control channel aligned with an external frame sync pulse. The counters run on the falling edges of the serial bit clock. Each bit of the serial stream is divided into four sub-bit phases. Eight bits, sent most significant first, make up one channel. A parameterised number of channels makes up one frame, and a parameterised number of frames makes up one multiframe.

The sync input can be sampled on either edge of the bit clock, chosen at run time. The counters always reload on a falling edge. When sync is taken on the rising edge, the reload happens at the falling edge that follows.

At a reload, the phase, bit and channel counters take programmed start positions. The multiframe counter is arranged so that the first complete frame after the sync carries a programmed frame number. Two registered strobes tell a neighbouring shift datapath when to capture the serial input and when to launch the serial outputs. After the first sync, later sync pulses are compared with the free-running position. A pulse at the expected position changes nothing. A pulse at any other position realigns the counters and raises an error flag for one cycle.

Top module: `tdm_frame_sync`

## Requirements
- R1: After reset, and until the first accepted sync pulse, the outputs are held at phase 0, bit 7, channel 0 and frame 0, with lock, both strobes and the error flag at 0.
- R2: With `edge_sel_i`=0, sync is sampled on the falling bit-clock edge, and that same edge reloads the counters. A pulse that is high only around a rising edge is ignored.
- R3: With `edge_sel_i`=1, sync is sampled on the rising edge, and the reload takes effect at the next falling edge. A pulse that is high only around a falling edge is ignored.
- R4: A reload sets the phase to `start_phase_i`, the bit to `start_bit_i` and the channel to `start_chan_i`. The value of `start_chan_i` must be below the channel count.
- R5: Once locked, the position advances on every falling edge. The phase runs 0,1,2,3. After phase 3 the bit number counts down from 7 to 0. After bit 0 the channel increments, and after the last channel it wraps to 0.
- R6: After a reload, the first position at or after the reload with phase 0, bit 7 and channel 0 (a frame start) shows `mf_start_i` as its frame number. Each later frame start adds 1, wrapping from MF_LEN-1 to 0.
- R7: `sample_stb_o` is high exactly in the bit-clock periods that begin at the falling edge opening phase 2, and only while locked.
- R8: `launch_stb_o` is high exactly in the bit-clock periods that begin at the falling edge opening phase 0, and only while locked.
- R9: The first accepted sync sets the lock, which stays set until reset. A later sync whose free-running next position equals the start position changes no counter (the frame number keeps counting) and raises no error.
- R10: A sync at any other position while locked reloads the counters and frame number as in R4 and R6, and raises `sync_err_o` for one bit-clock period.
- R11: The first sync after reset never raises `sync_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync pulse (polarity set by SYNC_ACTIVE_LOW) |
| edge_sel_i | input | 1 | 0: sample sync on the falling edge, 1: on the rising edge |
| start_phase_i | input | 2 | Sub-bit phase loaded at a reload |
| start_bit_i | input | 3 | Bit number loaded at a reload |
| start_chan_i | input | CH_W | Channel loaded at a reload |
| mf_start_i | input | FR_W | Frame number of the first complete frame after a reload |
| phase_o | output | 2 | Current sub-bit phase |
| bit_o | output | 3 | Current bit number within the channel |
| chan_o | output | CH_W | Current channel |
| frame_o | output | FR_W | Current multiframe position |
| locked_o | output | 1 | A sync has been accepted since reset |
| sample_stb_o | output | 1 | Serial input capture strobe (phase 2) |
| launch_stb_o | output | 1 | Serial output launch strobe (phase 0) |
| sync_err_o | output | 1 | One-cycle flag for a realigning sync |

## Verification
The phase, bit and channel registers drive the ports directly. A wrong step or a wrong reload value therefore shows up on `phase_o`, `bit_o` or `chan_o` within one bit-clock period. The strobes are kept in separate registers, so a strobe that disagrees with the visible phase shows up in the same period. A corrupted frame number appears at once after a reload. A missed or extra frame increment only shows at the next frame boundary, which is 32×N_CH periods later, so the checks are placed after one or more boundaries have been crossed. Errors in the alignment comparator show as `sync_err_o` being raised on a sync at the expected position, or as `frame_o` being reset when it should keep counting.

// File: rtl/tdm_sync_pkg.sv
package tdm_sync_pkg;
   localparam int PHASE_W = 2;
   localparam int BITN_W  = 3;

   localparam logic [PHASE_W-1:0] PH_FIRST  = 2'd0;
   localparam logic [PHASE_W-1:0] PH_LAST   = 2'd3;
   localparam logic [PHASE_W-1:0] PH_SAMPLE = 2'd2;
   localparam logic [PHASE_W-1:0] PH_LAUNCH = 2'd0;
   localparam logic [BITN_W-1:0]  BIT_FIRST = 3'd7;
   localparam logic [BITN_W-1:0]  BIT_LAST  = 3'd0;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } sync_edge_e;
endpackage

// File: rtl/tdm_sync_capture.sv
module tdm_sync_capture
   import tdm_sync_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sync_i,
   input  logic edge_sel_i,
   output logic hit_o
);
   logic sync_act;
   logic rise_q;

   generate
      if (ACTIVE_LOW) begin : g_inv
         assign sync_act = ~sync_i;
      end else begin : g_pass
         assign sync_act = sync_i;
      end
   endgenerate

   // sync seen at the rising edge, consumed at the following falling edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rise_q <= 1'b0;
      else         rise_q <= sync_act;
   end

   assign hit_o = (sync_edge_e'(edge_sel_i) == EDGE_RISE) ? rise_q : sync_act;

   // R3: in rising mode a hit needs a sync that was active at the last rising edge
   assert_rise_source_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (edge_sel_i && hit_o) |-> rise_q);
endmodule

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter
   import tdm_sync_pkg::*;
#(
   parameter int N_CH = 32,
   parameter int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 hit_i,
   input  logic [PHASE_W-1:0]   start_ph_i,
   input  logic [BITN_W-1:0]    start_bit_i,
   input  logic [CH_W-1:0]      start_ch_i,
   output logic [PHASE_W-1:0]   ph_o,
   output logic [BITN_W-1:0]    bit_o,
   output logic [CH_W-1:0]      ch_o,
   output logic                 lock_o,
   output logic                 err_o,
   output logic                 smp_o,
   output logic                 lch_o,
   output logic                 load_o,
   output logic                 load_at_start_o,
   output logic                 adv_o
);
   localparam logic [CH_W-1:0] CH_MAX = CH_W'(N_CH - 1);

   logic [PHASE_W-1:0] ph_q, ph_nat, ph_d;
   logic [BITN_W-1:0]  bit_q, bit_nat, bit_d;
   logic [CH_W-1:0]    ch_q, ch_nat, ch_d, ch_inc;
   logic               lock_q, err_q, smp_q, lch_q;
   logic               match, realign, nat_start, lock_d;

   generate
      if (N_CH == 1) begin : g_one_ch
         assign ch_inc = '0;
      end else begin : g_multi_ch
         assign ch_inc = (ch_q == CH_MAX) ? '0 : ch_q + 1'b1;
      end
   endgenerate

   // free-running step; idle until locked
   always_comb begin
      ph_nat  = ph_q;
      bit_nat = bit_q;
      ch_nat  = ch_q;
      if (lock_q) begin
         if (ph_q == PH_LAST) begin
            ph_nat = PH_FIRST;
            if (bit_q == BIT_LAST) begin
               bit_nat = BIT_FIRST;
               ch_nat  = ch_inc;
            end else begin
               bit_nat = bit_q - 1'b1;
            end
         end else begin
            ph_nat = ph_q + 1'b1;
         end
      end
   end

   assign match     = lock_q && (ph_nat == start_ph_i) && (bit_nat == start_bit_i)
                      && (ch_nat == start_ch_i);
   assign realign   = hit_i && !match;
   assign nat_start = (ph_nat == PH_FIRST) && (bit_nat == BIT_FIRST) && (ch_nat == '0);

   assign ph_d   = realign ? start_ph_i  : ph_nat;
   assign bit_d  = realign ? start_bit_i : bit_nat;
   assign ch_d   = realign ? start_ch_i  : ch_nat;
   assign lock_d = lock_q || hit_i;

   assign load_o          = realign;
   assign load_at_start_o = (start_ph_i == PH_FIRST) && (start_bit_i == BIT_FIRST)
                            && (start_ch_i == '0);
   assign adv_o           = lock_q && !realign && nat_start;

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q   <= PH_FIRST;
         bit_q  <= BIT_FIRST;
         ch_q   <= '0;
         lock_q <= 1'b0;
         err_q  <= 1'b0;
         smp_q  <= 1'b0;
         lch_q  <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         bit_q  <= bit_d;
         ch_q   <= ch_d;
         lock_q <= lock_d;
         err_q  <= hit_i && lock_q && !match;
         smp_q  <= lock_d && (ph_d == PH_SAMPLE);
         lch_q  <= lock_d && (ph_d == PH_LAUNCH);
      end
   end

   assign ph_o   = ph_q;
   assign bit_o  = bit_q;
   assign ch_o   = ch_q;
   assign lock_o = lock_q;
   assign err_o  = err_q;
   assign smp_o  = smp_q;
   assign lch_o  = lch_q;

   assert_chan_start_range_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
      hit_i |-> (int'(start_ch_i) < N_CH));

   assert_phase_step_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (lock_q && !hit_i) |=> (ph_q == $past(ph_q) + 2'd1));

   assert_bit_order_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (lock_q && !hit_i && ph_q == PH_LAST) |=>
      (bit_q == (($past(bit_q) == BIT_LAST) ? BIT_FIRST : $past(bit_q) - 3'd1)));

   assert_sample_phase_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
      smp_q |-> (lock_q && ph_q == PH_SAMPLE));

   assert_launch_phase_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
      lch_q |-> (lock_q && ph_q == PH_LAUNCH));

   assert_lock_sticky_R9: assert property (@(negedge clk_i) disable iff (!rst_ni)
      lock_q |=> lock_q);

   assert_first_sync_quiet_R11: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (hit_i && !lock_q) |=> !err_q);
endmodule

// File: rtl/tdm_mf_counter.sv
module tdm_mf_counter #(
   parameter int MF_LEN = 16,
   parameter int FR_W   = $clog2(MF_LEN)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            load_i,
   input  logic            load_at_start_i,
   input  logic            adv_i,
   input  logic [FR_W-1:0] mf_i,
   output logic [FR_W-1:0] frame_o
);
   localparam logic [FR_W-1:0] FR_MAX = FR_W'(MF_LEN - 1);

   logic [FR_W-1:0] frame_q, frame_inc, frame_pre;

   generate
      if ((1 << FR_W) == MF_LEN) begin : g_pow2
         assign frame_inc = frame_q + 1'b1;
         assign frame_pre = mf_i - 1'b1;
      end else begin : g_cmp
         assign frame_inc = (frame_q == FR_MAX) ? '0 : frame_q + 1'b1;
         assign frame_pre = (mf_i == '0) ? FR_MAX : mf_i - 1'b1;
      end
   endgenerate

   // a reload off a frame start sets one below, so the next frame start shows mf_i
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     frame_q <= '0;
      else if (load_i) frame_q <= load_at_start_i ? mf_i : frame_pre;
      else if (adv_i)  frame_q <= frame_inc;
   end

   assign frame_o = frame_q;

   assert_frame_step_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (adv_i && !load_i) |=>
      (frame_q == (($past(frame_q) == FR_MAX) ? '0 : $past(frame_q) + 1'b1)));

   assert_frame_load_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (load_i && load_at_start_i) |=> (frame_q == $past(mf_i)));

   assert_frame_hold_R9: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!adv_i && !load_i) |=> $stable(frame_q));
endmodule

// File: rtl/tdm_frame_sync.sv
module tdm_frame_sync
   import tdm_sync_pkg::*;
#(
   parameter int  N_CH            = 32,
   parameter int  MF_LEN          = 16,
   parameter bit  SYNC_ACTIVE_LOW = 1'b0,
   localparam int CH_W            = (N_CH > 1) ? $clog2(N_CH) : 1,
   localparam int FR_W            = $clog2(MF_LEN)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                sync_i,
   input  logic                edge_sel_i,
   input  logic [PHASE_W-1:0]  start_phase_i,
   input  logic [BITN_W-1:0]   start_bit_i,
   input  logic [CH_W-1:0]     start_chan_i,
   input  logic [FR_W-1:0]     mf_start_i,
   output logic [PHASE_W-1:0]  phase_o,
   output logic [BITN_W-1:0]   bit_o,
   output logic [CH_W-1:0]     chan_o,
   output logic [FR_W-1:0]     frame_o,
   output logic                locked_o,
   output logic                sample_stb_o,
   output logic                launch_stb_o,
   output logic                sync_err_o
);
   generate
      if (N_CH < 1) begin : g_bad_nch
         $error("tdm_frame_sync: N_CH must be at least 1");
      end
      if (MF_LEN < 2) begin : g_bad_mf
         $error("tdm_frame_sync: MF_LEN must be at least 2");
      end
   endgenerate

   logic hit, load, load_at_start, adv;

   tdm_sync_capture #(.ACTIVE_LOW(SYNC_ACTIVE_LOW)) u_capture (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_i     (sync_i),
      .edge_sel_i (edge_sel_i),
      .hit_o      (hit)
   );

   tdm_pos_counter #(.N_CH(N_CH), .CH_W(CH_W)) u_pos (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .hit_i           (hit),
      .start_ph_i      (start_phase_i),
      .start_bit_i     (start_bit_i),
      .start_ch_i      (start_chan_i),
      .ph_o            (phase_o),
      .bit_o           (bit_o),
      .ch_o            (chan_o),
      .lock_o          (locked_o),
      .err_o           (sync_err_o),
      .smp_o           (sample_stb_o),
      .lch_o           (launch_stb_o),
      .load_o          (load),
      .load_at_start_o (load_at_start),
      .adv_o           (adv)
   );

   tdm_mf_counter #(.MF_LEN(MF_LEN), .FR_W(FR_W)) u_mf (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .load_i          (load),
      .load_at_start_i (load_at_start),
      .adv_i           (adv),
      .mf_i            (mf_start_i),
      .frame_o         (frame_o)
   );

   assert_err_one_cycle_R10: assert property (@(negedge clk_i) disable iff (!rst_ni)
      sync_err_o |-> locked_o);
endmodule

// File: tb/tb_tdm_frame_sync.sv
module tb_tdm_frame_sync;
   localparam int NCH = 4;
   localparam int MFL = 16;
   localparam int FL  = NCH * 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync = 1'b0;
   logic       esel = 1'b0;
   logic [1:0] sph = '0;
   logic [2:0] sbt = 3'd7;
   logic [1:0] sch = '0;
   logic [3:0] smf = '0;
   logic [1:0] phase;
   logic [2:0] bitn;
   logic [1:0] chan;
   logic [3:0] frame;
   logic       locked, smp, lch, err;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tdm_frame_sync #(.N_CH(NCH), .MF_LEN(MFL)) dut (
      .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .edge_sel_i(esel),
      .start_phase_i(sph), .start_bit_i(sbt), .start_chan_i(sch), .mf_start_i(smf),
      .phase_o(phase), .bit_o(bitn), .chan_o(chan), .frame_o(frame),
      .locked_o(locked), .sample_stb_o(smp), .launch_stb_o(lch), .sync_err_o(err)
   );

   typedef struct packed {
      logic        sel;
      logic [1:0]  ph;
      logic [2:0]  bt;
      logic [1:0]  ch;
      logic [3:0]  mf;
      logic [15:0] k;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 2'd0, 3'd7, 2'd0, 4'd3,  16'd0},
      '{1'b0, 2'd0, 3'd7, 2'd0, 4'd3,  16'd5},
      '{1'b1, 2'd2, 3'd3, 2'd1, 4'd7,  16'd10},
      '{1'b1, 2'd3, 3'd0, 2'd3, 4'd0,  16'd1},
      '{1'b0, 2'd1, 3'd5, 2'd2, 4'd15, 16'd300},
      '{1'b0, 2'd0, 3'd7, 2'd0, 4'd15, 16'd128},
      '{1'b1, 2'd0, 3'd7, 2'd2, 4'd9,  16'd200},
      '{1'b0, 2'd3, 3'd7, 2'd0, 4'd5,  16'd40}
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      sync  = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   // returns 1 ns after the falling edge at which the sync takes effect
   task automatic do_sync();
      if (!esel) begin
         @(posedge clk); #1 sync = 1'b1;
         @(negedge clk); #1 sync = 1'b0;
      end else begin
         @(negedge clk); #1 sync = 1'b1;
         @(posedge clk); #1 sync = 1'b0;
         @(negedge clk); #1;
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   // position model: linear index within a frame
   task automatic check_pos(input string req, input int s, input int k, input int mf);
      int idx, fr0, fr;
      idx = (s + k) % FL;
      fr0 = (s == 0) ? mf : (mf + MFL - 1) % MFL;
      fr  = (fr0 + (s + k) / FL) % MFL;
      chk({req, " phase"}, int'(phase), idx % 4);
      chk({req, " bit"},   int'(bitn), 7 - ((idx / 4) % 8));
      chk({req, " chan"},  int'(chan), idx / 32);
      chk({req, " frame"}, int'(frame), fr);
   endtask

   function automatic int start_idx(input int ph, input int bt, input int ch);
      return (ch * 8 + (7 - bt)) * 4 + ph;
   endfunction

   initial begin
      #1_200_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state, held before any sync
      do_reset();
      tick(5);
      chk("R1 phase", int'(phase), 0);
      chk("R1 bit", int'(bitn), 7);
      chk("R1 chan", int'(chan), 0);
      chk("R1 frame", int'(frame), 0);
      chk("R1 lock", int'(locked), 0);
      chk("R1 sample", int'(smp), 0);
      chk("R1 launch", int'(lch), 0);
      chk("R1 err", int'(err), 0);

      // vector table: R2/R3 edge modes, R4 loads, R5 stepping, R6 frame numbering
      for (int v = 0; v < NV; v++) begin
         esel = VECS[v].sel;
         sph  = VECS[v].ph;
         sbt  = VECS[v].bt;
         sch  = VECS[v].ch;
         smf  = VECS[v].mf;
         do_reset();
         do_sync();
         tick(int'(VECS[v].k));
         check_pos(VECS[v].sel ? "R3 R4 R5 R6" : "R2 R4 R5 R6",
                   start_idx(int'(VECS[v].ph), int'(VECS[v].bt), int'(VECS[v].ch)),
                   int'(VECS[v].k), int'(VECS[v].mf));
         chk("R9 lock after sync", int'(locked), 1);
         chk("R11 no error on first sync", int'(err), 0);
      end

      // R7/R8 strobes
      esel = 1'b0; sph = 2'd1; sbt = 3'd7; sch = 2'd0; smf = 4'd0;
      do_reset();
      do_sync();
      #2;
      chk("R7 sample in phase 1", int'(smp), 0);
      chk("R8 launch in phase 1", int'(lch), 0);
      tick(1);
      chk("R7 sample in phase 2", int'(smp), 1);
      chk("R8 launch in phase 2", int'(lch), 0);
      tick(2);
      chk("R8 launch in phase 0", int'(lch), 1);
      chk("R7 sample in phase 0", int'(smp), 0);

      // R9 expected-position sync keeps counting
      esel = 1'b0; sph = 2'd0; sbt = 3'd7; sch = 2'd0; smf = 4'd4;
      do_reset();
      do_sync();
      #2;
      chk("R6 frame at reload on frame start", int'(frame), 4);
      repeat (FL - 1) @(negedge clk);
      do_sync();
      #2;
      chk("R9 no error on aligned sync", int'(err), 0);
      chk("R9 frame keeps counting", int'(frame), 5);
      chk("R9 phase", int'(phase), 0);

      // R10 misplaced sync realigns with a one-cycle flag
      repeat (9) @(negedge clk);
      do_sync();
      #2;
      chk("R10 error raised", int'(err), 1);
      chk("R10 frame reloaded", int'(frame), 4);
      chk("R10 phase reloaded", int'(phase), 0);
      chk("R10 bit reloaded", int'(bitn), 7);
      tick(1);
      chk("R10 error lasts one cycle", int'(err), 0);
      chk("R10 phase steps after reload", int'(phase), 1);

      // R3: rising-edge mode ignores a pulse seen only at a falling edge
      esel = 1'b1; sph = 2'd2; sbt = 3'd4; sch = 2'd1;
      do_reset();
      @(posedge clk); #1 sync = 1'b1;
      @(negedge clk); #1 sync = 1'b0;
      tick(2);
      chk("R3 falling-only pulse ignored", int'(locked), 0);
      // R3: taken at rising edge, effective at the next falling edge
      @(negedge clk); #1 sync = 1'b1;
      @(posedge clk); #1 sync = 1'b0;
      #1;
      chk("R3 not yet applied before falling edge", int'(locked), 0);
      @(negedge clk); #2;
      chk("R3 applied at falling edge lock", int'(locked), 1);
      chk("R3 applied at falling edge phase", int'(phase), 2);
      chk("R3 applied at falling edge bit", int'(bitn), 4);

      // R2: falling-edge mode ignores a pulse seen only at a rising edge
      esel = 1'b0;
      do_reset();
      @(negedge clk); #1 sync = 1'b1;
      @(posedge clk); #1 sync = 1'b0;
      tick(2);
      chk("R2 rising-only pulse ignored", int'(locked), 0);
      chk("R2 position held", int'(phase), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule